// File: doc/BRIEF.md
# Lock-Tracking Reset Sequencer

This block produces the design-wide logic reset for a programmable device that has no built-in way to restart all of its logic. When the device reset (`arstN`) is released, an internal counter runs from zero to a fixed length and then stops. The logic reset stays asserted during that count and for as long as the clock generator reports no lock. Once lock is seen, a settle count runs. Only after that does the logic reset release, and the release passes through a two-stage synchronizer. Assertion does not wait for a clock: `arstN` or a loss of lock clears the synchronizer at once.

Software restarts the logic with a single-cycle request (`swReq`). The block then drives the clock generator's reset input for a fixed number of cycles. It waits for lock to return, runs the settle count again and only then releases the logic reset. Lock is not permanent, so every drop of lock returns the block to waiting and restarts the settle count.

A separate reconfiguration path drives an active-low pin that restarts the whole device. That path only acts when an arming input is also high. Once driven low, the pin stays low until the device reset takes effect, which covers the pin's minimum low time whatever the clock rate. A 3-bit phase output shows where the sequence is.

Top module: `rst_sequencer`

## Requirements
- R1: After `arstN` rises, `phase` stays at 0 (power-up count) for PWRUP_CYCLES rising edges. If `pllLocked` is held high, `logicRstN` first reads 1 after rising edge PWRUP_CYCLES+SETTLE_CYCLES+3 counted from the release.
- R2: When `pllLocked` goes low, `logicRstN` goes low at once without waiting for a clock edge. If the block was running and no request is present, `phase` becomes 2 (wait-for-lock) after the next edge.
- R3: When lock returns during wait-for-lock, `phase` moves to 3 (settle) at the next edge and stays there for SETTLE_CYCLES edges, then moves to 4 (running). `logicRstN` first reads 1 after edge SETTLE_CYCLES+3 counted from the relock. A loss of lock during settle returns `phase` to 2, and the settle count starts over.
- R4: When `swReq` is sampled high while `phase` is 4, `phase` becomes 1 (PLL reset) after that edge. `pllReset` is then high for exactly PLL_CYCLES cycles, after which `phase` is 2.
- R5: `swReq` has no effect while `phase` is 0, 1 or 2. The power-up length, the PLL reset pulse length and the wait for lock are unchanged by it.
- R6: When `swReq` is sampled high while `phase` is 3, the sequence restarts at phase 1. This holds even if lock is lost in the same cycle.
- R7: When the block leaves phase 4 because of a software request while lock stays high, `logicRstN` is still 1 after the first and second edges and reads 0 after the third edge, counted from the edge that samples the request.
- R8: `reconfN` is 1 after reset. `reconfReq` without `reconfArm` leaves it at 1.
- R9: An edge that samples `reconfArm` and `reconfReq` both high drives `reconfN` to 0. It then stays 0 whatever the inputs do, and returns to 1 only when `arstN` is asserted.
- R10: `phase` encodes the sequence as 0 power-up count, 1 PLL reset, 2 wait-for-lock, 3 settle, 4 running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| arstN | input | 1 | Asynchronous active-low device reset, released after configuration |
| swReq | input | 1 | Software request for a logic reset sequence, one cycle |
| pllLocked | input | 1 | Lock indication from the clock generator |
| reconfArm | input | 1 | Enables the reconfiguration request |
| reconfReq | input | 1 | Request to drive the full reconfiguration pin |
| pllReset | output | 1 | Reset input of the clock generator, active high |
| logicRstN | output | 1 | Design-wide logic reset, active low |
| reconfN | output | 1 | Full-device reconfiguration pin, active low |
| phase | output | 3 | Current sequence phase (see R10) |

## Verification
Phase changes are due one edge after the input that causes them is sampled. The release of `logicRstN` comes two edges after the running phase is entered. The loss-of-lock assertion is due with no edge at all, so the bench looks at it one time step after changing `pllLocked`. All inputs change just after a falling edge, and every output is read just after the following falling edge. The checks of lengths and release times count these half-cycle steps from the moment the stimulus is applied. The random part compares every step against a bench model of the phase and of the two synchronizer stages, and that model updates on the same rising edges as the design.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    PH_PWRUP    = 3'd0,
    PH_PLLRST   = 3'd1,
    PH_WAITLOCK = 3'd2,
    PH_SETTLE   = 3'd3,
    PH_RUN      = 3'd4
  } seqPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic relRun;
    logic pllRst;
  } seqStrobe_t;

endpackage

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       swReq,
  input  logic       pllLocked,
  input  logic       pwrupDone,
  input  logic       pllDone,
  input  logic       settleDone,
  output seqStrobe_t strobe,
  output seqPhase_t  state
);

  seqPhase_t stateNxt;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= PH_PWRUP;
    else        state <= stateNxt;
  end

  always_comb begin
    stateNxt      = state;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    strobe.relRun = (state == PH_RUN);
    strobe.pllRst = (state == PH_PLLRST);
    unique case (state)
      PH_PWRUP: begin
        if (pwrupDone) begin
          stateNxt      = PH_WAITLOCK;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PH_PLLRST: begin
        if (pllDone) begin
          stateNxt      = PH_WAITLOCK;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PH_WAITLOCK: begin
        strobe.cntClr = 1'b1;
        if (pllLocked) stateNxt = PH_SETTLE;
      end
      PH_SETTLE: begin
        if (swReq) begin
          stateNxt      = PH_PLLRST;
          strobe.cntClr = 1'b1;
        end else if (!pllLocked) begin
          stateNxt      = PH_WAITLOCK;
          strobe.cntClr = 1'b1;
        end else if (settleDone) begin
          stateNxt      = PH_RUN;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PH_RUN: begin
        strobe.cntClr = 1'b1;
        if (swReq)           stateNxt = PH_PLLRST;
        else if (!pllLocked) stateNxt = PH_WAITLOCK;
      end
      default: begin
        stateNxt      = PH_PWRUP;
        strobe.cntClr = 1'b1;
      end
    endcase
  end

  AST_LOCK_LOSS_WAIT: assert property (@(posedge clk) disable iff (!arstN)
    (state == PH_RUN && !pllLocked && !swReq) |=> (state == PH_WAITLOCK)); // R2

  AST_WAIT_IGNORES_REQ: assert property (@(posedge clk) disable iff (!arstN)
    (state == PH_WAITLOCK && !pllLocked) |=> (state == PH_WAITLOCK)); // R5

  AST_PWRUP_IGNORES_REQ: assert property (@(posedge clk) disable iff (!arstN)
    (state == PH_PWRUP && !pwrupDone) |=> (state == PH_PWRUP)); // R5

  AST_SETTLE_RESTART: assert property (@(posedge clk) disable iff (!arstN)
    (state == PH_SETTLE && swReq) |=> (state == PH_PLLRST)); // R6

endmodule

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int PWRUP_CYCLES  = 16,
  parameter int PLL_CYCLES    = 8,
  parameter int SETTLE_CYCLES = 12
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       pllLocked,
  input  logic       reconfArm,
  input  logic       reconfReq,
  input  seqStrobe_t strobe,
  output logic       pwrupDone,
  output logic       pllDone,
  output logic       settleDone,
  output logic       logicRstN,
  output logic       reconfN
);

  localparam int MAX_A = (PWRUP_CYCLES > PLL_CYCLES) ? PWRUP_CYCLES : PLL_CYCLES;
  localparam int MAX_C = (MAX_A > SETTLE_CYCLES) ? MAX_A : SETTLE_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       relSync;
  logic             syncClrN;
  logic             reconfLow;

  // shared phase counter
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)             cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  assign pwrupDone  = (cnt == CNT_W'(PWRUP_CYCLES - 1));
  assign pllDone    = (cnt == CNT_W'(PLL_CYCLES - 1));
  assign settleDone = (cnt == CNT_W'(SETTLE_CYCLES - 1));

  // release synchronizer: cleared at once by device reset or loss of lock
  assign syncClrN = arstN & pllLocked;

  always_ff @(posedge clk or negedge syncClrN) begin
    if (!syncClrN) relSync <= 2'b00;
    else           relSync <= {relSync[0], strobe.relRun};
  end

  assign logicRstN = relSync[1];

  // reconfiguration pin: sticky until the device reset
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                       reconfLow <= 1'b0;
    else if (reconfArm && reconfReq)  reconfLow <= 1'b1;
  end

  assign reconfN = ~reconfLow;

  AST_REL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!arstN)
    logicRstN |-> pllLocked); // R2

  AST_REL_AFTER_RUN: assert property (@(posedge clk) disable iff (!arstN)
    $rose(logicRstN) |-> $past(strobe.relRun, 2)); // R3

  AST_RECONF_STICKY: assert property (@(posedge clk) disable iff (!arstN)
    !reconfN |=> !reconfN); // R9

  AST_RECONF_ARMED: assert property (@(posedge clk) disable iff (!arstN)
    $fell(reconfN) |-> $past(reconfArm && reconfReq)); // R8

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int PWRUP_CYCLES  = 16,
  parameter int PLL_CYCLES    = 8,
  parameter int SETTLE_CYCLES = 12
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       swReq,
  input  logic       pllLocked,
  input  logic       reconfArm,
  input  logic       reconfReq,
  output logic       pllReset,
  output logic       logicRstN,
  output logic       reconfN,
  output logic [2:0] phase
);

  seqStrobe_t strobe;
  seqPhase_t  state;
  logic       pwrupDone;
  logic       pllDone;
  logic       settleDone;

  rst_seq_ctrl i_ctrl (
    .clk        (clk),
    .arstN      (arstN),
    .swReq      (swReq),
    .pllLocked  (pllLocked),
    .pwrupDone  (pwrupDone),
    .pllDone    (pllDone),
    .settleDone (settleDone),
    .strobe     (strobe),
    .state      (state)
  );

  rst_seq_dp #(
    .PWRUP_CYCLES  (PWRUP_CYCLES),
    .PLL_CYCLES    (PLL_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) i_dp (
    .clk        (clk),
    .arstN      (arstN),
    .pllLocked  (pllLocked),
    .reconfArm  (reconfArm),
    .reconfReq  (reconfReq),
    .strobe     (strobe),
    .pwrupDone  (pwrupDone),
    .pllDone    (pllDone),
    .settleDone (settleDone),
    .logicRstN  (logicRstN),
    .reconfN    (reconfN)
  );

  assign pllReset = strobe.pllRst;
  assign phase    = state;

  // checker: length of the clock generator reset pulse
  localparam int PC_W = $clog2(PLL_CYCLES + 2);
  logic [PC_W-1:0] pllHighCnt;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)        pllHighCnt <= '0;
    else if (pllReset) pllHighCnt <= pllHighCnt + 1'b1;
    else               pllHighCnt <= '0;
  end

  AST_PLL_PULSE_LEN: assert property (@(posedge clk) disable iff (!arstN)
    $fell(pllReset) |-> (pllHighCnt == PC_W'(PLL_CYCLES))); // R4

endmodule

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int P  = 16;
  localparam int L  = 8;
  localparam int S  = 12;
  localparam int LOCK_DELAY = 5;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic swReq = 1'b0;
  logic lockUser = 1'b1;
  logic dropOnRst = 1'b1;
  logic reconfArm = 1'b0;
  logic reconfReq = 1'b0;
  int   relockCnt = 0;
  logic pllLocked;
  logic pllReset, logicRstN, reconfN;
  logic [2:0] phase;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pllLocked = lockUser && (relockCnt == 0);

  rst_sequencer i_rst_sequencer (
    .clk       (clk),
    .arstN     (arstN),
    .swReq     (swReq),
    .pllLocked (pllLocked),
    .reconfArm (reconfArm),
    .reconfReq (reconfReq),
    .pllReset  (pllReset),
    .logicRstN (logicRstN),
    .reconfN   (reconfN),
    .phase     (phase)
  );

  // clock generator model: loses lock while held in reset, relocks later
  always @(negedge clk) begin
    if (pllReset && dropOnRst) relockCnt <= LOCK_DELAY;
    else if (relockCnt > 0)    relockCnt <= relockCnt - 1;
  end

  // reference model of phase and release stages, from the requirements
  int   mPh = 0;
  int   mCnt = 0;
  logic mS1 = 1'b0, mS2 = 1'b0;

  function automatic int nextPhase(int ph, int cnt, logic req, logic lk);
    case (ph)
      0: return (cnt == P-1) ? 2 : 0;
      1: return (cnt == L-1) ? 2 : 1;
      2: return lk ? 3 : 2;
      3: return req ? 1 : (!lk ? 2 : ((cnt == S-1) ? 4 : 3));
      default: return req ? 1 : (!lk ? 2 : 4);
    endcase
  endfunction

  always @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      mPh <= 0; mCnt <= 0; mS1 <= 1'b0; mS2 <= 1'b0;
    end else begin
      mPh  <= nextPhase(mPh, mCnt, swReq, pllLocked);
      mCnt <= (nextPhase(mPh, mCnt, swReq, pllLocked) != mPh || mPh == 2 || mPh == 4)
              ? 0 : mCnt + 1;
      mS1  <= (mPh == 4) && pllLocked;
      mS2  <= mS1 && pllLocked;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // count steps until logicRstN reads 1
  task automatic countToRelease(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!logicRstN && n < 400);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    int hi;
    void'($urandom(32'd20240611));

    // reset state
    repeat (3) step();
    chk(phase == 3'd0, "R10", "phase in reset", phase, 0);
    chk(logicRstN == 1'b0, "R1", "logicRstN in reset", logicRstN, 0);
    chk(pllReset == 1'b0, "R4", "pllReset in reset", pllReset, 0);
    chk(reconfN == 1'b1, "R8", "reconfN in reset", reconfN, 1);

    // power-up count with an ignored request (R1, R5)
    arstN = 1'b1;
    n = 0;
    do begin
      step();
      n++;
      if (n == 3) swReq = 1'b1;
      else        swReq = 1'b0;
      if (n == 5) chk(phase == 3'd0, "R1", "phase during power-up", phase, 0);
    end while (!logicRstN && n < 400);
    chk(n == P+S+3, "R1", "power-up release step (request ignored, R5)", n, P+S+3);
    chk(phase == 3'd4, "R10", "running phase", phase, 4);

    // loss of lock asserts at once (R2)
    lockUser = 1'b0;
    #1;
    chk(logicRstN == 1'b0, "R2", "immediate reset on lock loss", logicRstN, 0);
    step();
    chk(phase == 3'd2, "R2", "phase after lock loss", phase, 2);
    repeat (3) step();
    lockUser = 1'b1;
    n = 0;
    do begin
      step();
      n++;
      if (n == 2) chk(phase == 3'd3, "R3", "settle after relock", phase, 3);
    end while (!logicRstN && n < 400);
    chk(n == S+3, "R3", "release after relock", n, S+3);

    // lock loss during settle restarts the count (R3)
    lockUser = 1'b0;
    step();
    lockUser = 1'b1;
    repeat (4) step();
    chk(phase == 3'd3, "R3", "settle before second loss", phase, 3);
    lockUser = 1'b0;
    step();
    chk(phase == 3'd2, "R3", "settle abandoned on loss", phase, 2);
    lockUser = 1'b1;
    countToRelease(n);
    chk(n == S+3, "R3", "release after settle restart", n, S+3);

    // software request with lock kept: synchronous assertion (R7)
    dropOnRst = 1'b0;
    swReq = 1'b1;
    step();
    swReq = 1'b0;
    chk(phase == 3'd1 && pllReset, "R4", "PLL reset phase entered", phase, 1);
    chk(logicRstN == 1'b1, "R7", "release held after first edge", logicRstN, 1);
    step();
    chk(logicRstN == 1'b1, "R7", "release held after second edge", logicRstN, 1);
    step();
    chk(logicRstN == 1'b0, "R7", "asserted after third edge", logicRstN, 0);
    countToRelease(n);

    // pulse length, request during pulse and during wait ignored (R4, R5)
    dropOnRst = 1'b1;
    swReq = 1'b1;
    step();
    swReq = 1'b0;
    hi = 0;
    while (pllReset && hi < 400) begin
      hi++;
      swReq = (hi == 3);
      step();
    end
    swReq = 1'b0;
    chk(hi == L, "R4", "pllReset pulse length (request in pulse ignored, R5)", hi, L);
    chk(phase == 3'd2, "R4", "wait-for-lock after pulse", phase, 2);
    swReq = 1'b1;
    step();
    swReq = 1'b0;
    chk(phase == 3'd2, "R5", "request in wait-for-lock ignored", phase, 2);

    // request in settle restarts, priority over lock loss (R6)
    n = 0;
    do begin
      step();
      n++;
    end while (phase != 3'd3 && n < 400);
    swReq = 1'b1;
    lockUser = 1'b0;
    step();
    swReq = 1'b0;
    lockUser = 1'b1;
    chk(phase == 3'd1, "R6", "restart from settle", phase, 1);
    countToRelease(n);

    // random traffic against the reference model (R1..R6)
    arstN = 1'b0;
    step();
    arstN = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      step();
      chk(phase == mPh[2:0], "R3", "random phase", phase, mPh);
      chk(logicRstN == (mS2 && pllLocked), "R2", "random logicRstN",
          logicRstN, int'(mS2 && pllLocked));
      swReq = ($urandom_range(19) == 0);
      if (lockUser) lockUser = ($urandom_range(39) != 0);
      else          lockUser = ($urandom_range(5) == 0);
    end
    swReq = 1'b0;
    lockUser = 1'b1;

    // reconfiguration pin (R8, R9)
    reconfReq = 1'b1;
    step();
    step();
    chk(reconfN == 1'b1, "R8", "unarmed request ignored", reconfN, 1);
    reconfArm = 1'b1;
    step();
    chk(reconfN == 1'b0, "R9", "armed request drives low", reconfN, 0);
    reconfArm = 1'b0;
    reconfReq = 1'b0;
    swReq = 1'b1;
    step();
    swReq = 1'b0;
    repeat (60) step();
    chk(reconfN == 1'b0, "R9", "pin stays low", reconfN, 0);
    arstN = 1'b0;
    #1;
    chk(reconfN == 1'b1, "R9", "released by device reset", reconfN, 1);

    summary();
    $finish;
  end

endmodule